// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is a small datapath built around one shared internal bus. Eight general-purpose registers, a temporary operand register A and a result register C all hang off that bus. A short sequencer runs each operation as a series of timed control states. In every state it raises exactly one output enable, which picks the bus driver, and the load strobes of the registers that capture that state's result.

A caller issues an operation with a single-cycle start strobe. The strobe carries:
- an operation code,
- a destination register field,
- two source register fields,
- an external data word.

Three operations are supported:
- **Add** takes three ordered bus steps.
- **Move** copies one register to another in a single step, in either direction between any two registers.
- **Load** writes the captured external word into a register in a single step.

A done flag pulses once when the operation has completed. A read port returns the contents of any register so that it can be observed.

Top module: `bus_dp_top`

## Requirements
- R1: The register file holds eight registers, selected by a 3-bit straight binary code (R0 = 000 through R7 = 111). The read port `peek_data` returns the register selected by `peek_sel` in the same cycle.
- R2: A synchronous reset clears all eight registers, A, C and the sequencer. After reset, `busy` and `done` are low and every register reads 0.
- R3: An add (op 01) computes dst = src1 + src2 in three strictly ordered steps:
  1. src1 drives the bus and A is loaded.
  2. src2 drives the bus and A + bus is loaded into C.
  3. C drives the bus and dst is loaded.
  The destination holds the new value after the third rising edge that follows the start edge.
- R4: The adder works modulo 2^16. A sum that overflows wraps around, and no carry is kept.
- R5: A move (op 00) copies src1 into dst in one bus step: the source output enable and the destination load are active in the same cycle. dst holds the value after the first edge that follows the start edge.
- R6: Moves work in both directions between any two registers, and a move leaves its source unchanged.
- R7: A load (op 10) captures `ext_data` with the start strobe and writes it into dst in one bus step.
- R8: At most one source drives the bus in any cycle, and at most one general-purpose register loads in any cycle. The value a register receives is exactly the value of the single enabled driver.
- R9: `done` is high for exactly one cycle, in the cycle after the final step. `busy` is high from the cycle after the accepted start through the final step.
- R10: A start strobe that arrives while `busy` is high is ignored. It changes no register and produces no extra `done` pulse.
- R11: Op code 11 is reserved. A start that carries it is ignored: `busy` and `done` stay low and no register changes.
- R12: An add whose destination is also one or both of its sources uses the source values from before the operation, for example R1 = R1 + R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operation strobe, sampled when idle |
| op_sel | input | 2 | 00 move, 01 add, 10 load, 11 reserved |
| dst_sel | input | 3 | Destination register code |
| src1_sel | input | 3 | First source register code (the move source) |
| src2_sel | input | 3 | Second source register code (add only) |
| ext_data | input | 16 | Data word for a load, captured with start |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| peek_sel | input | 3 | Register read select |
| peek_data | output | 16 | Contents of the selected register |

## Verification
The start strobe is sampled at a rising edge; call it edge 0. For an add, the destination changes and `done` rises after edge 3. For a move or a load, both happen after edge 1. `done` falls again one edge later.

The bench drives its inputs on falling edges. After each start it counts falling edges until `done` appears, and compares that count with 3 or 1. It then reads registers through the combinational read port just after that falling edge, and checks that `done` is low at the following falling edge.

The tests for ignored strobes hold `start` high across each edge of a busy operation. They then watch several further cycles for any stray `done` pulse or register change.

// File: rtl/bus_dp_pkg.sv
package bus_dp_pkg;

   typedef enum logic [1:0] {
      OP_MOVE = 2'b00,
      OP_ADD  = 2'b01,
      OP_LOAD = 2'b10,
      OP_RSVD = 2'b11
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADD1 = 3'd1,
      ST_ADD2 = 3'd2,
      ST_ADD3 = 3'd3,
      ST_XFER = 3'd4
   } state_e;

endpackage

// File: rtl/bus_dp_seq.sv
module bus_dp_seq
   import bus_dp_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [1:0]    op_sel,
   input  logic [AW-1:0] dst_sel,
   input  logic [AW-1:0] src1_sel,
   input  logic [AW-1:0] src2_sel,
   output logic          accept,
   output logic          src_en,
   output logic [AW-1:0] src_idx,
   output logic          ext_oe,
   output logic          c_oe,
   output logic          a_ld,
   output logic          c_ld,
   output logic          dst_en,
   output logic [AW-1:0] dst_idx,
   output logic          busy,
   output logic          done
);

   state_e        state_q;
   op_e           op_q;
   logic [AW-1:0] dst_q, s1_q, s2_q;
   logic          last_step;

   // A start is taken only from idle, and never with the reserved code.
   assign accept = start && (state_q == ST_IDLE) && (op_e'(op_sel) != OP_RSVD);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         op_q    <= OP_MOVE;
         dst_q   <= '0;
         s1_q    <= '0;
         s2_q    <= '0;
         done    <= 1'b0;
      end else begin
         done <= last_step;
         if (accept) begin
            op_q  <= op_e'(op_sel);
            dst_q <= dst_sel;
            s1_q  <= src1_sel;
            s2_q  <= src2_sel;
         end
         unique case (state_q)
            ST_IDLE: if (accept) state_q <= (op_e'(op_sel) == OP_ADD) ? ST_ADD1 : ST_XFER;
            ST_ADD1: state_q <= ST_ADD2;
            ST_ADD2: state_q <= ST_ADD3;
            ST_ADD3: state_q <= ST_IDLE;
            ST_XFER: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      last_step = (state_q == ST_ADD3) || (state_q == ST_XFER);
      busy      = (state_q != ST_IDLE);
      a_ld      = (state_q == ST_ADD1);
      c_ld      = (state_q == ST_ADD2);
      c_oe      = (state_q == ST_ADD3);
      ext_oe    = (state_q == ST_XFER) && (op_q == OP_LOAD);
      src_en    = (state_q == ST_ADD1) || (state_q == ST_ADD2)
                  || ((state_q == ST_XFER) && (op_q == OP_MOVE));
      src_idx   = (state_q == ST_ADD2) ? s2_q : s1_q;
      dst_en    = last_step;
      dst_idx   = dst_q;
   end

endmodule

// File: rtl/bus_dp_regbank.sv
module bus_dp_regbank #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   parameter int AW   = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NREG-1:0]    ld_oh,
   input  logic [DW-1:0]      bus,
   input  logic [AW-1:0]      peek_sel,
   output logic [DW-1:0]      peek_data,
   output logic [NREG*DW-1:0] q_flat
);

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)           q <= '0;
         else if (ld_oh[i]) q <= bus;
      end
      assign q_flat[i*DW +: DW] = q;
   end

   always_comb begin
      peek_data = '0;
      for (int k = 0; k < NREG; k++)
         if (peek_sel == AW'(k)) peek_data = q_flat[k*DW +: DW];
   end

endmodule

// File: rtl/bus_dp_bus.sv
module bus_dp_bus #(
   parameter int DW   = 16,
   parameter int NREG = 8
) (
   input  logic [NREG*DW-1:0] reg_flat,
   input  logic [NREG-1:0]    reg_oe,
   input  logic [DW-1:0]      c_q,
   input  logic               c_oe,
   input  logic [DW-1:0]      ext_q,
   input  logic               ext_oe,
   output logic [DW-1:0]      bus
);

   // Gated AND-OR merge stands in for the tri-state drivers.
   logic [DW-1:0] term [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_term
      assign term[i] = reg_flat[i*DW +: DW] & {DW{reg_oe[i]}};
   end

   always_comb begin
      bus = (c_q & {DW{c_oe}}) | (ext_q & {DW{ext_oe}});
      for (int k = 0; k < NREG; k++) bus = bus | term[k];
   end

endmodule

// File: rtl/bus_dp_accum.sv
module bus_dp_accum #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          a_ld,
   input  logic          c_ld,
   input  logic [DW-1:0] bus,
   output logic [DW-1:0] c_q
);

   logic [DW-1:0] a_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         c_q <= '0;
      end else begin
         if (a_ld) a_q <= bus;
         if (c_ld) c_q <= a_q + bus;
      end
   end

endmodule

// File: rtl/bus_dp_top.sv
module bus_dp_top #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   parameter int AW   = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [1:0]    op_sel,
   input  logic [AW-1:0] dst_sel,
   input  logic [AW-1:0] src1_sel,
   input  logic [AW-1:0] src2_sel,
   input  logic [DW-1:0] ext_data,
   output logic          done,
   output logic          busy,
   input  logic [AW-1:0] peek_sel,
   output logic [DW-1:0] peek_data
);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("bus_dp_top: NREG must be a power of two, at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("bus_dp_top: DW must be at least 2");
   end
   if (AW != $clog2(NREG)) begin : g_bad_aw
      $error("bus_dp_top: AW must equal clog2(NREG)");
   end

   logic               accept, src_en, ext_oe, c_oe, a_ld, c_ld, dst_en;
   logic [AW-1:0]      src_idx, dst_idx;
   logic [NREG-1:0]    reg_oe_oh, reg_ld_oh;
   logic [NREG*DW-1:0] reg_flat;
   logic [DW-1:0]      bus, c_q, ext_q;

   bus_dp_seq #(.AW(AW)) i_seq (
      .clk, .rst, .start, .op_sel, .dst_sel, .src1_sel, .src2_sel,
      .accept, .src_en, .src_idx, .ext_oe, .c_oe, .a_ld, .c_ld,
      .dst_en, .dst_idx, .busy, .done
   );

   for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign reg_oe_oh[i] = src_en && (src_idx == AW'(i));
      assign reg_ld_oh[i] = dst_en && (dst_idx == AW'(i));
   end

   always_ff @(posedge clk) begin
      if (rst)         ext_q <= '0;
      else if (accept) ext_q <= ext_data;
   end

   bus_dp_regbank #(.DW(DW), .NREG(NREG), .AW(AW)) i_regs (
      .clk, .rst, .ld_oh(reg_ld_oh), .bus, .peek_sel, .peek_data, .q_flat(reg_flat)
   );

   bus_dp_bus #(.DW(DW), .NREG(NREG)) i_bus (
      .reg_flat, .reg_oe(reg_oe_oh), .c_q, .c_oe, .ext_q, .ext_oe, .bus
   );

   bus_dp_accum #(.DW(DW)) i_acc (
      .clk, .rst, .a_ld, .c_ld, .bus, .c_q
   );

endmodule

// File: rtl/bus_dp_chk.sv
module bus_dp_chk #(
   parameter int NREG = 8
) (
   input logic            clk,
   input logic            rst,
   input logic            busy,
   input logic            done,
   input logic [NREG-1:0] reg_oe,
   input logic [NREG-1:0] reg_ld,
   input logic            c_oe,
   input logic            ext_oe,
   input logic            a_ld,
   input logic            c_ld
);

   a_r8_one_driver: assert property (@(posedge clk) disable iff (rst)
      $onehot0({reg_oe, c_oe, ext_oe}));

   a_r8_one_load: assert property (@(posedge clk) disable iff (rst)
      $onehot0(reg_ld));

   a_r3_a_before_c: assert property (@(posedge clk) disable iff (rst)
      c_ld |-> $past(a_ld));

   a_r3_c_before_dst: assert property (@(posedge clk) disable iff (rst)
      c_oe |-> $past(c_ld));

   a_r3_dst_from_c: assert property (@(posedge clk) disable iff (rst)
      c_oe |-> ($countones(reg_ld) == 1));

   a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
      (|reg_ld && !c_oe) |-> ((|reg_oe) || ext_oe));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(busy) && !busy));

endmodule

bind bus_dp_top bus_dp_chk #(.NREG(NREG)) i_chk (
   .clk(clk), .rst(rst), .busy(busy), .done(done),
   .reg_oe(reg_oe_oh), .reg_ld(reg_ld_oh),
   .c_oe(c_oe), .ext_oe(ext_oe), .a_ld(a_ld), .c_ld(c_ld)
);

// File: tb/test_bus_dp_top.sv
`timescale 1ns/1ps
module test_bus_dp_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [2:0]  dst_sel = '0, src1_sel = '0, src2_sel = '0, peek_sel = '0;
   logic [15:0] ext_data = '0;
   logic        done, busy;
   logic [15:0] peek_data;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   logic [15:0] m [8];

   always #2 clk = ~clk;

   bus_dp_top i_bus_dp_top (
      .clk, .rst, .start, .op_sel, .dst_sel, .src1_sel, .src2_sel,
      .ext_data, .done, .busy, .peek_sel, .peek_data
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_reg(string tag, int idx);
      peek_sel = 3'(idx);
      #0.5;
      check($sformatf("%s R%0d", tag, idx), 32'(peek_data), 32'(m[idx]));
   endtask

   task automatic chk_all(string tag);
      for (int i = 0; i < 8; i++) chk_reg(tag, i);
   endtask

   // Returns at the falling edge right after the start edge.
   task automatic issue(logic [1:0] op, int d, int s1, int s2, logic [15:0] x);
      @(negedge clk);
      start = 1'b1; op_sel = op; dst_sel = 3'(d);
      src1_sel = 3'(s1); src2_sel = 3'(s2); ext_data = x;
      @(negedge clk);
      start = 1'b0; ext_data = 16'hDEAD;
   endtask

   task automatic wait_done(string tag, int exp_cyc);
      int cyc = 0;
      while (!done && cyc < 8) begin
         @(negedge clk);
         cyc++;
      end
      check({tag, " done latency"}, 32'(cyc), 32'(exp_cyc));
   endtask

   task automatic after_done(string tag);
      @(negedge clk);
      check({tag, " R9 done one cycle"}, 32'(done), 32'd0);
      check({tag, " R9 busy low"}, 32'(busy), 32'd0);
   endtask

   task automatic op_load(int d, logic [15:0] x);
      issue(2'b10, d, 0, 0, x);
      wait_done("R7 load", 1);
      m[d] = x;
      chk_reg("R7 load", d);
      after_done("R7 load");
   endtask

   task automatic op_move(string tag, int d, int s);
      issue(2'b00, d, s, 0, 16'h0);
      wait_done({tag, " R5 move"}, 1);
      m[d] = m[s];
      chk_all({tag, " R5 move"});
      after_done({tag, " R5 move"});
   endtask

   task automatic op_add(string tag, int d, int s1, int s2);
      logic [15:0] sum;
      sum = m[s1] + m[s2];
      issue(2'b01, d, s1, s2, 16'h0);
      check({tag, " R9 busy during add"}, 32'(busy), 32'd1);
      wait_done({tag, " R3 add"}, 3);
      m[d] = sum;
      chk_all({tag, " R3 add"});
      after_done({tag, " R3 add"});
   endtask

   task automatic t_reset();
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 8; i++) m[i] = '0;
      check("R2 done after reset", 32'(done), 32'd0);
      check("R2 busy after reset", 32'(busy), 32'd0);
      chk_all("R2 reset");
   endtask

   task automatic t_load_all();
      for (int i = 0; i < 8; i++) op_load(i, 16'h1111 * 16'(i) + 16'h0102);
      chk_all("R1 peek after loads");
   endtask

   task automatic t_add_basic();
      op_add("basic", 4, 3, 2);
      op_add("R1 other codes", 7, 0, 6);
   endtask

   task automatic t_add_wrap();
      op_load(5, 16'hFFF0);
      op_load(6, 16'h0025);
      op_add("R4 wrap", 1, 5, 6);
      check("R4 wrapped sum", 32'(m[1]), 32'h0015);
   endtask

   task automatic t_move_dirs();
      op_load(2, 16'h00F0);
      op_move("fwd", 3, 2);
      op_load(3, 16'h0A0B);
      op_move("R6 reverse", 2, 3);
      check("R8 exact single driver", 32'(m[2]), 32'h0A0B);
   endtask

   task automatic t_alias();
      op_load(1, 16'h4321);
      op_add("R12 dst=src1=src2", 1, 1, 1);
      check("R12 doubled", 32'(m[1]), 32'h8642);
      op_add("R12 dst=src2", 0, 4, 0);
   endtask

   task automatic t_busy_ignore();
      int pulses = 0;
      logic [15:0] sum;
      sum = m[1] + m[2];
      issue(2'b01, 5, 1, 2, 16'h0);
      start = 1'b1; op_sel = 2'b00; dst_sel = 3'd6; src1_sel = 3'd0;
      @(negedge clk);
      op_sel = 2'b10; ext_data = 16'hBEEF;
      @(negedge clk);
      op_sel = 2'b01; dst_sel = 3'd6; src1_sel = 3'd3; src2_sel = 3'd3;
      @(negedge clk);
      start = 1'b0;
      check("R10 add still completes", 32'(done), 32'd1);
      m[5] = sum;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (done) pulses++;
      end
      check("R10 no extra done", 32'(pulses), 32'd0);
      chk_all("R10 ignored start");
   endtask

   task automatic t_reserved();
      int seen = 0;
      issue(2'b11, 2, 3, 4, 16'h5A5A);
      check("R11 busy stays low", 32'(busy), 32'd0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (done || busy) seen++;
      end
      check("R11 no done", 32'(seen), 32'd0);
      chk_all("R11 reserved");
   endtask

   initial begin
      t_reset();
      t_load_all();
      t_add_basic();
      t_add_wrap();
      t_move_dirs();
      t_alias();
      t_busy_ignore();
      t_reserved();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule